// File: doc/BRIEF.md
# Paged Memory Map Translation Unit

This block turns a 15-bit logical word address into a 20-bit physical word address. The upper five bits of the logical address pick one of 32 map entries. The low ten bits of that entry become the upper ten bits of the physical address. The ten-bit displacement passes through unchanged, so the block can reach one million words. Two further bits in each entry guard the page. One bit forbids reads and the other forbids writes. An access that breaks either rule raises a fault and gets no memory strobe.

There are two complete map files. One serves processor accesses and the other serves DMA accesses. A loader can therefore point DMA traffic at different physical regions from the processor's view. Entries are loaded through a simple write port. Translation is purely combinational from the request inputs. A global enable turns mapping off, and the block then passes the logical address straight through, zero-extended.

Top module: `page_map_xlate`

## Requirements
- R1: After reset, entry n of both map files holds the value n with both guard bits clear, so enabled translation is an identity map over the first 32K words and raises no fault.
- R2: With mapping enabled, physAddr is {entry[9:0], reqAddr[9:0]}, where the entry is selected by reqAddr[14:10]. The result appears combinationally in the same cycle as the request.
- R3: When wrEn is high at a rising edge, wrData is stored in entry wrIndex of the file chosen by wrSel (0 = processor, 1 = DMA). A translation in that same cycle still sees the old entry, and the new value applies from the next cycle on.
- R4: A write to one map file leaves every entry of the other file unchanged.
- R5: reqSrc picks the file used for translation: 0 selects the processor file and 1 selects the DMA file.
- R6: Entry bit 11 is the read guard. An enabled, valid read (reqWrite = 0) through an entry with bit 11 set drives fault high and memStrobe low.
- R7: Entry bit 10 is the write guard. An enabled, valid write (reqWrite = 1) through an entry with bit 10 set drives fault high and memStrobe low. An access in the direction that is not guarded proceeds normally.
- R8: With mapEnable low, physAddr is {5'b0, reqAddr}, and no fault is raised whatever the guard bits hold.
- R9: memStrobe equals reqValid with no fault present. Fault is never high while reqValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mapEnable | input | 1 | 1 = translate through the maps, 0 = pass the address through |
| wrEn | input | 1 | Map entry write strobe |
| wrSel | input | 1 | Map file to write: 0 = processor, 1 = DMA |
| wrIndex | input | 5 | Entry number to write |
| wrData | input | 12 | Entry value: bit 11 = read guard, bit 10 = write guard, bits 9:0 = frame |
| reqValid | input | 1 | Access request present |
| reqSrc | input | 1 | Requester: 0 = processor, 1 = DMA |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | 15 | Logical word address |
| physAddr | output | 20 | Physical word address |
| memStrobe | output | 1 | Memory access strobe, withheld on a fault |
| fault | output | 1 | Protection violation |

## Verification
A corrupted map entry cannot stay hidden. The first access to that page from the matching requester shows a wrong upper physical field in the same cycle. A guard bit that is wrongly set or lost shows up at once as a flipped fault and memStrobe pair. That happens on the first access in the guarded direction. A write that reaches the wrong file, or lands a cycle early, is caught by reading both files back through translation: once in the write cycle and again in the cycles after it.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PAGE_BITS  = 5;
  localparam int DISP_BITS  = 10;
  localparam int FRAME_BITS = 10;
  localparam int PROT_BITS  = 2;
  localparam int NUM_SETS   = 2;

  localparam int ENTRY_W   = FRAME_BITS + PROT_BITS;
  localparam int LADDR_W   = PAGE_BITS + DISP_BITS;
  localparam int PADDR_W   = FRAME_BITS + DISP_BITS;
  localparam int NUM_PAGES = 1 << PAGE_BITS;
  localparam int SET_BITS  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int WP_BIT    = FRAME_BITS;      // write guard
  localparam int RP_BIT    = FRAME_BITS + 1;  // read guard

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SETS-1:0]  load;
    logic [PAGE_BITS-1:0] index;
    logic [ENTRY_W-1:0]   data;
    logic                 xlateOn;
  } mapCtl_t;
endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mapEnable,
  input  logic                 wrEn,
  input  logic [SET_BITS-1:0]  wrSel,
  input  logic [PAGE_BITS-1:0] wrIndex,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ENTRY_W-1:0]   selEntry,
  output mapCtl_t              ctl,
  output logic                 fault,
  output logic                 memStrobe
);
  logic readBlocked;
  logic writeBlocked;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_load
    assign ctl.load[s] = wrEn && (wrSel == SET_BITS'(s));
  end

  assign ctl.index   = wrIndex;
  assign ctl.data    = wrData;
  assign ctl.xlateOn = mapEnable;

  always_comb begin
    readBlocked  = !reqWrite && selEntry[RP_BIT];
    writeBlocked =  reqWrite && selEntry[WP_BIT];
    fault        = reqValid && mapEnable && (readBlocked || writeBlocked);
    memStrobe    = reqValid && !fault;
  end

  p_strobe_fault_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(memStrobe && fault));
  p_fault_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> reqValid);
  p_no_fault_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapEnable |-> !fault);
  p_read_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !reqWrite) |-> selEntry[RP_BIT]);
  p_write_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && reqWrite) |-> selEntry[WP_BIT]);
endmodule

// File: rtl/pmx_datapath.sv
module pmx_datapath
  import pmx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  mapCtl_t             ctl,
  input  logic [SET_BITS-1:0] reqSrc,
  input  logic [LADDR_W-1:0]  reqAddr,
  output logic [ENTRY_W-1:0]  selEntry,
  output logic [PADDR_W-1:0]  physAddr
);
  logic [ENTRY_W-1:0]   mapReg   [NUM_SETS][NUM_PAGES];
  logic [ENTRY_W-1:0]   setEntry [NUM_SETS];
  logic [PAGE_BITS-1:0] page;

  assign page = reqAddr[LADDR_W-1:DISP_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int p = 0; p < NUM_PAGES; p++)
          mapReg[s][p] <= ENTRY_W'(p);
    end else begin
      for (int s = 0; s < NUM_SETS; s++)
        if (ctl.load[s]) mapReg[s][ctl.index] <= ctl.data;
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_setRead
    assign setEntry[s] = mapReg[s][page];
  end

  always_comb begin
    selEntry = setEntry[reqSrc];
    if (ctl.xlateOn)
      physAddr = {selEntry[FRAME_BITS-1:0], reqAddr[DISP_BITS-1:0]};
    else
      physAddr = PADDR_W'(reqAddr);
  end

  p_onehot_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl.load));
  p_dma_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load[0] && !ctl.load[1]) |=>
      mapReg[1][$past(ctl.index)] == $past(mapReg[1][ctl.index]));
  p_cpu_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load[1] && !ctl.load[0]) |=>
      mapReg[0][$past(ctl.index)] == $past(mapReg[0][ctl.index]));
endmodule

// File: rtl/page_map_xlate.sv
module page_map_xlate
  import pmx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mapEnable,
  input  logic                 wrEn,
  input  logic [SET_BITS-1:0]  wrSel,
  input  logic [PAGE_BITS-1:0] wrIndex,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic                 reqValid,
  input  logic [SET_BITS-1:0]  reqSrc,
  input  logic                 reqWrite,
  input  logic [LADDR_W-1:0]   reqAddr,
  output logic [PADDR_W-1:0]   physAddr,
  output logic                 memStrobe,
  output logic                 fault
);
  mapCtl_t            ctl;
  logic [ENTRY_W-1:0] selEntry;

  pmx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mapEnable (mapEnable),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrIndex   (wrIndex),
    .wrData    (wrData),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .selEntry  (selEntry),
    .ctl       (ctl),
    .fault     (fault),
    .memStrobe (memStrobe)
  );

  pmx_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .reqSrc   (reqSrc),
    .reqAddr  (reqAddr),
    .selEntry (selEntry),
    .physAddr (physAddr)
  );

  p_disp_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    physAddr[DISP_BITS-1:0] == reqAddr[DISP_BITS-1:0]);
endmodule

// File: tb/page_map_xlate_tb.sv
`timescale 1ns/1ps
module page_map_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mapEnable = 1'b1, wrEn = 1'b0, wrSel = 1'b0;
  logic [4:0]  wrIndex = '0;
  logic [11:0] wrData = '0;
  logic        reqValid = 1'b0, reqSrc = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [19:0] physAddr;
  logic        memStrobe, fault;

  always #2 clk = ~clk;

  page_map_xlate u_dut (.*);

  typedef struct packed { logic [19:0] phys; logic strobe; logic flt; } expItem_t;
  expItem_t expQ[$];
  string    tagQ[$];
  bit [11:0] mdl [2][32];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic step(input bit en, input bit valid, input bit src, input bit wr,
                      input logic [14:0] addr, input bit wen, input bit wsel,
                      input logic [4:0] widx, input logic [11:0] wdata,
                      input string tag, input bit chk);
    expItem_t e;
    bit [11:0] ent;
    @(negedge clk);
    mapEnable = en; reqValid = valid; reqSrc = src; reqWrite = wr; reqAddr = addr;
    wrEn = wen; wrSel = wsel; wrIndex = widx; wrData = wdata;
    if (chk) begin
      ent = mdl[src][addr[14:10]];
      e.phys   = en ? {ent[9:0], addr[9:0]} : {5'b0, addr};
      e.flt    = valid && en && (wr ? ent[10] : ent[11]);
      e.strobe = valid && !e.flt;
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    @(posedge clk);
    if (wen) mdl[wsel][widx] = wdata;
  endtask

  task automatic xlate(input bit en, input bit src, input bit wr,
                       input logic [14:0] addr, input string tag);
    step(en, 1'b1, src, wr, addr, 1'b0, 1'b0, 5'd0, 12'd0, tag, 1'b1);
  endtask

  task automatic load(input bit wsel, input logic [4:0] widx, input logic [11:0] wdata);
    step(1'b1, 1'b0, 1'b0, 1'b0, 15'd0, 1'b1, wsel, widx, wdata, "", 1'b0);
  endtask

  // monitor: compares one cycle's outputs against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (physAddr !== e.phys || memStrobe !== e.strobe || fault !== e.flt) begin
          fails++;
          $display("FAIL %s: phys=%05h strobe=%0b fault=%0b expected phys=%05h strobe=%0b fault=%0b",
                   t, physAddr, memStrobe, fault, e.phys, e.strobe, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 32; p++) mdl[s][p] = 12'(p);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;  // R1 reset: idle outputs quiet
    if (memStrobe !== 1'b0 || fault !== 1'b0) begin
      fails++;
      $display("FAIL R1: strobe=%0b fault=%0b expected strobe=0 fault=0", memStrobe, fault);
    end

    // R1 identity map in both files, no guards
    xlate(1, 0, 0, {5'd3,  10'h155}, "R1");
    xlate(1, 1, 1, {5'd31, 10'h3FF}, "R1");
    xlate(1, 0, 1, {5'd0,  10'h000}, "R1");
    // R2 several patterns after loading frames
    load(0, 5'd12, 12'h3A5);
    xlate(1, 0, 0, {5'd12, 10'h2C3}, "R2");
    xlate(1, 0, 1, {5'd12, 10'h001}, "R2");
    xlate(1, 0, 0, {5'd13, 10'h0F0}, "R2");
    // R3 same-cycle write sees old value, next cycle sees new
    step(1, 1, 0, 0, {5'd5, 10'h123}, 1, 0, 5'd5, 12'h2AB, "R3", 1);
    xlate(1, 0, 0, {5'd5, 10'h123}, "R3");
    // R4 other file untouched
    xlate(1, 1, 0, {5'd5, 10'h123}, "R4");
    xlate(1, 1, 0, {5'd12, 10'h2C3}, "R4");
    // R5 source selects the file
    load(1, 5'd7, 12'h155);
    xlate(1, 1, 0, {5'd7, 10'h0AA}, "R5");
    xlate(1, 0, 0, {5'd7, 10'h0AA}, "R5");
    // R6 read guard
    load(0, 5'd9, 12'h810);
    xlate(1, 0, 0, {5'd9, 10'h044}, "R6");
    xlate(1, 0, 1, {5'd9, 10'h044}, "R6");
    xlate(1, 1, 0, {5'd9, 10'h044}, "R6");
    // R7 write guard
    load(1, 5'd2, 12'h7FF);
    xlate(1, 1, 1, {5'd2, 10'h321}, "R7");
    xlate(1, 1, 0, {5'd2, 10'h321}, "R7");
    xlate(1, 0, 1, {5'd2, 10'h321}, "R7");
    // R8 mapping off: pass-through, no fault
    xlate(0, 0, 0, {5'd9, 10'h044}, "R8");
    xlate(0, 1, 1, {5'd2, 10'h321}, "R8");
    xlate(0, 0, 0, {5'd12, 10'h2C3}, "R8");
    // R9 no request: no strobe, no fault even on guarded page
    step(1, 0, 0, 0, {5'd9, 10'h044}, 0, 0, 5'd0, 12'd0, "R9", 1);
    step(1, 0, 1, 1, {5'd2, 10'h321}, 0, 0, 5'd0, 12'd0, "R9", 1);
    // R3 overwrite clears a guard
    load(0, 5'd9, 12'h011);
    xlate(1, 0, 0, {5'd9, 10'h044}, "R3");

    step(1, 0, 0, 0, 15'd0, 0, 0, 5'd0, 12'd0, "", 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule